// File: doc/BRIEF.md
# Programmable SRAM bus cycle timer

This block runs one access at a time to an external asynchronous SRAM-style memory region. It turns a request from an internal port (address, direction and write data) into active-low chip-select, read-strobe and write-strobe waveforms. When the access completes it returns a one-cycle done pulse, together with the read data for a read.

Two 3-bit fields in a 32-bit timing register set the shape of each access. The setup field sets the gap from chip-select falling to write-strobe falling. That gap always carries half a clock cycle beyond the programmed count, because the write strobe is launched from the falling clock edge. The hold field sets the gap from read-strobe rising to chip-select rising.

Both fields reset to their slowest value. A two-bit mode input tells the block which kind of memory sits on the region. For the memory kinds that honour programmed timing, the fields are used. For the remaining kind, both delays collapse to zero.

Top module: `sram_cycle_timer`

## Requirements
- R1: After reset cs_n_o, rd_n_o and we_n_o are 1, req_ready_o is 1, and cfg_rdata_o reads 0x0007_7000: the hold field (bits 18:16) and the setup field (bits 14:12) both hold 7.
- R2: A write on the configuration port stores bits 18:16 as the hold field and bits 14:12 as the setup field. Every other bit of cfg_rdata_o always reads 0, whatever was written.
- R3: In a write access, we_n_o falls S + 0.5 clock cycles after cs_n_o falls, where S is the effective setup count.
- R4: In a read access, rd_n_o falls together with cs_n_o, and cs_n_o rises H clock cycles after rd_n_o rises, where H is the effective hold count.
- R5: For mode_i codes 0, 1 and 2, S and H are the setup and hold fields. For mode_i code 3, both fields are ignored and S = H = 0.
- R6: rd_n_o and we_n_o each stay low for STROBE_CYC clock cycles (default 2). After a write, cs_n_o rises half a cycle after we_n_o rises.
- R7: rdata_o holds the value of mem_din_i sampled on the clock edge at which rd_n_o rises, and is valid while done_o is 1.
- R8: done_o is a one-cycle pulse that starts on the clock edge at which cs_n_o rises.
- R9: req_ready_o is 0 from the edge that accepts a request until cs_n_o rises. A request presented while req_ready_o is 0 is ignored.
- R10: rd_n_o and we_n_o are never low together, and neither is low while cs_n_o is high. During a write, mem_addr_o and mem_dout_o carry the request's address and data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | Memory kind of the region; 0 to 2 honour programmed timing, 3 forces zero delays |
| cfg_wr_i | input | 1 | Timing register write enable |
| cfg_wdata_i | input | 32 | Timing register write value |
| cfg_rdata_o | output | 32 | Timing register read value |
| req_valid_i | input | 1 | Access request |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | AW | Access address |
| req_wdata_i | input | DW | Write data |
| req_ready_o | output | 1 | Idle and able to accept a request |
| done_o | output | 1 | Access complete pulse |
| rdata_o | output | DW | Read data |
| mem_addr_o | output | AW | Memory address |
| mem_dout_o | output | DW | Memory write data |
| mem_din_i | input | DW | Memory read data |
| cs_n_o | output | 1 | Chip select, active low |
| rd_n_o | output | 1 | Read strobe, active low |
| we_n_o | output | 1 | Write strobe, active low |

## Verification
A table of setup/hold/mode combinations drives one write and one read per row. The zero codes and code 7 appear in the table, and the forcing mode is paired with both large and zero fields. This separates a wrong field position, a missing half-cycle offset, an off-by-one in the counters and a mode gate that fails to zero the delays. Edge-to-edge gaps are taken from strobe edge times, so a half cycle cannot hide inside a whole-cycle sample. Directed cases cover the reset timing, reserved-bit writes, and a request held against a busy cycle.

// File: rtl/sram_timer_pkg.sv
`timescale 1ns/1ps
package sram_timer_pkg;
   localparam int FIELD_W  = 3;
   localparam int HOLD_LSB = 16;
   localparam int SETUP_LSB = 12;
   localparam logic [1:0] MODE_NO_TIMING = 2'd3;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_SETUP,
      ST_STROBE,
      ST_HOLD
   } cyc_state_e;
endpackage

// File: rtl/sram_timing_reg.sv
`timescale 1ns/1ps
module sram_timing_reg
   import sram_timer_pkg::*;
#(
   parameter int REG_W = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_i,
   input  logic [REG_W-1:0]   wdata_i,
   output logic [FIELD_W-1:0] setup_o,
   output logic [FIELD_W-1:0] hold_o,
   output logic [REG_W-1:0]   rdata_o
);
   initial begin
      assert (REG_W > HOLD_LSB + FIELD_W - 1)
         else $error("REG_W too narrow for timing fields");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         setup_o <= '1;
         hold_o  <= '1;
      end else if (wr_i) begin
         setup_o <= wdata_i[SETUP_LSB +: FIELD_W];
         hold_o  <= wdata_i[HOLD_LSB +: FIELD_W];
      end
   end

   always_comb begin
      rdata_o = '0;
      rdata_o[SETUP_LSB +: FIELD_W] = setup_o;
      rdata_o[HOLD_LSB +: FIELD_W]  = hold_o;
   end
endmodule

// File: rtl/sram_cycle_fsm.sv
`timescale 1ns/1ps
module sram_cycle_fsm
   import sram_timer_pkg::*;
#(
   parameter int AW = 16,
   parameter int DW = 32,
   parameter int STROBE_CYC = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [FIELD_W-1:0] setup_i,
   input  logic [FIELD_W-1:0] hold_i,
   input  logic               req_valid_i,
   input  logic               req_write_i,
   input  logic [AW-1:0]      req_addr_i,
   input  logic [DW-1:0]      req_wdata_i,
   output logic               ready_o,
   output logic               done_o,
   output logic [DW-1:0]      rdata_o,
   output logic [AW-1:0]      mem_addr_o,
   output logic [DW-1:0]      mem_dout_o,
   input  logic [DW-1:0]      mem_din_i,
   output logic               cs_n_o,
   output logic               rd_n_o,
   output logic               we_rise_o
);
   localparam int CNT_MAX = (STROBE_CYC > 8) ? STROBE_CYC : 8;
   localparam int CNT_W   = $clog2(CNT_MAX + 1);
   localparam logic [CNT_W-1:0] STROBE_LAST = CNT_W'(STROBE_CYC - 1);

   initial begin
      assert (STROBE_CYC >= 1) else $error("STROBE_CYC must be at least 1");
   end

   cyc_state_e       state;
   logic [CNT_W-1:0] cnt;
   logic             is_wr;
   logic [CNT_W-1:0] tail;

   assign ready_o = (state == ST_IDLE);
   assign tail    = is_wr ? CNT_W'(1) : CNT_W'(hold_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         cnt        <= '0;
         is_wr      <= 1'b0;
         cs_n_o     <= 1'b1;
         rd_n_o     <= 1'b1;
         we_rise_o  <= 1'b0;
         done_o     <= 1'b0;
         rdata_o    <= '0;
         mem_addr_o <= '0;
         mem_dout_o <= '0;
      end else begin
         done_o <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               if (req_valid_i) begin
                  is_wr      <= req_write_i;
                  mem_addr_o <= req_addr_i;
                  mem_dout_o <= req_wdata_i;
                  cs_n_o     <= 1'b0;
                  if (!req_write_i) begin
                     rd_n_o <= 1'b0;
                     state  <= ST_STROBE;
                     cnt    <= STROBE_LAST;
                  end else if (setup_i == '0) begin
                     we_rise_o <= 1'b1;
                     state     <= ST_STROBE;
                     cnt       <= STROBE_LAST;
                  end else begin
                     state <= ST_SETUP;
                     cnt   <= CNT_W'(setup_i) - CNT_W'(1);
                  end
               end
            end
            ST_SETUP: begin
               if (cnt == '0) begin
                  we_rise_o <= 1'b1;
                  state     <= ST_STROBE;
                  cnt       <= STROBE_LAST;
               end else begin
                  cnt <= cnt - CNT_W'(1);
               end
            end
            ST_STROBE: begin
               if (cnt == '0) begin
                  rd_n_o    <= 1'b1;
                  we_rise_o <= 1'b0;
                  if (!is_wr) rdata_o <= mem_din_i;
                  if (tail == '0) begin
                     cs_n_o <= 1'b1;
                     done_o <= 1'b1;
                     state  <= ST_IDLE;
                  end else begin
                     state <= ST_HOLD;
                     cnt   <= tail - CNT_W'(1);
                  end
               end else begin
                  cnt <= cnt - CNT_W'(1);
               end
            end
            ST_HOLD: begin
               if (cnt == '0) begin
                  cs_n_o <= 1'b1;
                  done_o <= 1'b1;
                  state  <= ST_IDLE;
               end else begin
                  cnt <= cnt - CNT_W'(1);
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/sram_we_shaper.sv
`timescale 1ns/1ps
module sram_we_shaper #(
   parameter bit HALF_OFFSET = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic we_rise_i,
   output logic we_n_o
);
   generate
      if (HALF_OFFSET) begin : g_fall_edge
         always_ff @(negedge clk or negedge rst_n) begin
            if (!rst_n) we_n_o <= 1'b1;
            else        we_n_o <= ~we_rise_i;
         end
      end else begin : g_same_edge
         assign we_n_o = ~we_rise_i;
      end
   endgenerate
endmodule

// File: rtl/sram_cycle_timer.sv
`timescale 1ns/1ps
module sram_cycle_timer
   import sram_timer_pkg::*;
#(
   parameter int AW = 16,
   parameter int DW = 32,
   parameter int STROBE_CYC = 2,
   parameter bit HALF_OFFSET = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [1:0]    mode_i,
   input  logic          cfg_wr_i,
   input  logic [31:0]   cfg_wdata_i,
   output logic [31:0]   cfg_rdata_o,
   input  logic          req_valid_i,
   input  logic          req_write_i,
   input  logic [AW-1:0] req_addr_i,
   input  logic [DW-1:0] req_wdata_i,
   output logic          req_ready_o,
   output logic          done_o,
   output logic [DW-1:0] rdata_o,
   output logic [AW-1:0] mem_addr_o,
   output logic [DW-1:0] mem_dout_o,
   input  logic [DW-1:0] mem_din_i,
   output logic          cs_n_o,
   output logic          rd_n_o,
   output logic          we_n_o
);
   initial begin
      assert (AW >= 1 && DW >= 1) else $error("AW and DW must be positive");
   end

   logic [FIELD_W-1:0] setup_f, hold_f, setup_eff, hold_eff;
   logic               timing_on, we_rise;

   sram_timing_reg #(.REG_W(32)) u_reg (
      .clk(clk), .rst_n(rst_n), .wr_i(cfg_wr_i), .wdata_i(cfg_wdata_i),
      .setup_o(setup_f), .hold_o(hold_f), .rdata_o(cfg_rdata_o)
   );

   assign timing_on = (mode_i != MODE_NO_TIMING);
   assign setup_eff = timing_on ? setup_f : '0;
   assign hold_eff  = timing_on ? hold_f  : '0;

   sram_cycle_fsm #(.AW(AW), .DW(DW), .STROBE_CYC(STROBE_CYC)) u_fsm (
      .clk(clk), .rst_n(rst_n), .setup_i(setup_eff), .hold_i(hold_eff),
      .req_valid_i(req_valid_i), .req_write_i(req_write_i),
      .req_addr_i(req_addr_i), .req_wdata_i(req_wdata_i),
      .ready_o(req_ready_o), .done_o(done_o), .rdata_o(rdata_o),
      .mem_addr_o(mem_addr_o), .mem_dout_o(mem_dout_o), .mem_din_i(mem_din_i),
      .cs_n_o(cs_n_o), .rd_n_o(rd_n_o), .we_rise_o(we_rise)
   );

   sram_we_shaper #(.HALF_OFFSET(HALF_OFFSET)) u_we (
      .clk(clk), .rst_n(rst_n), .we_rise_i(we_rise), .we_n_o(we_n_o)
   );
endmodule

// File: rtl/sram_cycle_timer_checks.sv
`timescale 1ns/1ps
module sram_cycle_timer_checks (
   input logic        clk,
   input logic        rst_n,
   input logic [31:0] cfg_rdata_o,
   input logic        req_valid_i,
   input logic        req_ready_o,
   input logic        done_o,
   input logic        cs_n_o,
   input logic        rd_n_o,
   input logic        we_n_o
);
   // R1 / R9: idle means every strobe is released
   a_r1_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready_o |-> (cs_n_o && rd_n_o && we_n_o));

   // R10: strobes only inside chip select
   a_r10_strobe_in_cs: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_n_o || !we_n_o) |-> !cs_n_o);

   // R10: never both strobes
   a_r10_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      !(!rd_n_o && !we_n_o));

   // R8: done lasts one cycle
   a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // R8: done starts as chip select rises
   a_r8_done_at_cs_rise: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (cs_n_o && !$past(cs_n_o)));

   // R9: accepted request makes the block busy with chip select low
   a_r9_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid_i && req_ready_o) |=> (!cs_n_o && !req_ready_o));

   // R2: reserved bits read zero
   a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_rdata_o & ~32'h0007_7000) == 32'h0);
endmodule

bind sram_cycle_timer sram_cycle_timer_checks u_checks (
   .clk(clk), .rst_n(rst_n), .cfg_rdata_o(cfg_rdata_o),
   .req_valid_i(req_valid_i), .req_ready_o(req_ready_o), .done_o(done_o),
   .cs_n_o(cs_n_o), .rd_n_o(rd_n_o), .we_n_o(we_n_o)
);

// File: tb/sram_cycle_timer_test.sv
`timescale 1ns/1ps
module sram_cycle_timer_test;
   localparam int PERIOD = 10;
   localparam int AW = 16;
   localparam int DW = 32;
   localparam int STROBE = 2;
   localparam int NVEC = 8;
   // each entry: {mode[1:0], setup[2:0], hold[2:0]}
   localparam logic [7:0] VEC [NVEC] = '{
      {2'd0, 3'd0, 3'd0}, {2'd0, 3'd7, 3'd7}, {2'd1, 3'd2, 3'd5},
      {2'd2, 3'd5, 3'd1}, {2'd3, 3'd6, 3'd4}, {2'd3, 3'd0, 3'd7},
      {2'd0, 3'd3, 3'd0}, {2'd2, 3'd1, 3'd6}};

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [1:0]    mode = 2'd0;
   logic          cfg_wr = 1'b0;
   logic [31:0]   cfg_wdata = '0;
   logic [31:0]   cfg_rdata;
   logic          req_valid = 1'b0, req_write = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_wdata = '0;
   logic          ready, done;
   logic [DW-1:0] rdata, mem_dout, mem_din;
   logic [AW-1:0] mem_addr;
   logic          cs_n, rd_n, we_n;

   int  errors = 0, checks = 0, we_falls = 0;
   bit  finished = 0;
   time t_cs_fall, t_cs_rise, t_rd_fall, t_rd_rise, t_we_fall, t_we_rise;
   logic [AW-1:0] wr_addr_seen;
   logic [DW-1:0] wr_data_seen;

   always #(PERIOD/2) clk = ~clk;
   assign mem_din = {mem_addr, ~mem_addr};

   sram_cycle_timer #(.AW(AW), .DW(DW), .STROBE_CYC(STROBE)) uut (
      .clk(clk), .rst_n(rst_n), .mode_i(mode), .cfg_wr_i(cfg_wr),
      .cfg_wdata_i(cfg_wdata), .cfg_rdata_o(cfg_rdata),
      .req_valid_i(req_valid), .req_write_i(req_write), .req_addr_i(req_addr),
      .req_wdata_i(req_wdata), .req_ready_o(ready), .done_o(done),
      .rdata_o(rdata), .mem_addr_o(mem_addr), .mem_dout_o(mem_dout),
      .mem_din_i(mem_din), .cs_n_o(cs_n), .rd_n_o(rd_n), .we_n_o(we_n));

   always @(negedge cs_n) t_cs_fall = $time;
   always @(posedge cs_n) t_cs_rise = $time;
   always @(negedge rd_n) t_rd_fall = $time;
   always @(posedge rd_n) t_rd_rise = $time;
   always @(negedge we_n) begin t_we_fall = $time; we_falls++; end
   always @(posedge we_n) begin
      t_we_rise = $time; wr_addr_seen = mem_addr; wr_data_seen = mem_dout;
   end

   task automatic check(input string req, input longint act, input longint exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic cfg_write(input logic [31:0] v);
      @(negedge clk); cfg_wr = 1'b1; cfg_wdata = v;
      @(posedge clk); #1; cfg_wr = 1'b0;
   endtask

   task automatic start_req(input logic wr, input logic [AW-1:0] a, input logic [DW-1:0] d);
      @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
      @(posedge clk); #1; req_valid = 1'b0;
   endtask

   task automatic wait_done(input string req);
      int n = 0;
      @(negedge clk);
      while (!done && n < 200) begin @(negedge clk); n++; end
      check(req, done, 1);
   endtask

   task automatic run_pair(input int i, input logic [1:0] md, input int s, input int h);
      logic [AW-1:0] a;
      logic [DW-1:0] d;
      int se, he;
      a = AW'(16'h0100 + i * 16'h0111);
      d = 32'hC0DE_0000 + 32'(i * 32'h1357);
      se = (md == 2'd3) ? 0 : s;
      he = (md == 2'd3) ? 0 : h;
      mode = md;
      cfg_write({13'b0, 3'(h), 1'b0, 3'(s), 12'b0});
      start_req(1'b1, a, d);
      wait_done("R8 write done");
      check("R3/R5 write setup ns", longint'(t_we_fall - t_cs_fall), longint'(se * PERIOD + PERIOD / 2));
      check("R6 write strobe ns", longint'(t_we_rise - t_we_fall), longint'(STROBE * PERIOD));
      check("R6 cs after we ns", longint'(t_cs_rise - t_we_rise), longint'(PERIOD / 2));
      check("R10 write addr", wr_addr_seen, a);
      check("R10 write data", wr_data_seen, d);
      @(negedge clk);
      check("R8 done one cycle", done, 0);
      start_req(1'b0, a ^ 16'h00FF, '0);
      wait_done("R8 read done");
      check("R4 rd with cs ns", longint'(t_rd_fall - t_cs_fall), 0);
      check("R4/R5 read hold ns", longint'(t_cs_rise - t_rd_rise), longint'(he * PERIOD));
      check("R6 read strobe ns", longint'(t_rd_rise - t_rd_fall), longint'(STROBE * PERIOD));
      check("R7 read data", rdata, {a ^ 16'h00FF, ~(a ^ 16'h00FF)});
   endtask

   initial begin
      #(PERIOD * 150000);
      if (!finished) begin
         errors++; checks++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1 cs_n", cs_n, 1);
      check("R1 rd_n", rd_n, 1);
      check("R1 we_n", we_n, 1);
      check("R1 ready", ready, 1);
      check("R1 cfg reset value", cfg_rdata, 32'h0007_7000);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R1 slowest timing applies after reset
      start_req(1'b1, 16'h0042, 32'h1234_5678);
      wait_done("R1 write done");
      check("R1 reset setup ns", longint'(t_we_fall - t_cs_fall), longint'(7 * PERIOD + PERIOD / 2));
      start_req(1'b0, 16'h0043, '0);
      wait_done("R1 read done");
      check("R1 reset hold ns", longint'(t_cs_rise - t_rd_rise), longint'(7 * PERIOD));

      // R2 register fields and reserved bits
      cfg_write(32'hFFFF_FFFF);
      @(negedge clk);
      check("R2 all ones", cfg_rdata, 32'h0007_7000);
      cfg_write(32'hFFF8_8FFF);
      @(negedge clk);
      check("R2 reserved only", cfg_rdata, 32'h0);
      cfg_write(32'h0003_5000);
      @(negedge clk);
      check("R2 fields", cfg_rdata, 32'h0003_5000);

      // table of timing vectors
      for (int i = 0; i < NVEC; i++)
         run_pair(i, VEC[i][7:6], int'(VEC[i][5:3]), int'(VEC[i][2:0]));

      // R9 request while busy is ignored
      mode = 2'd0;
      cfg_write({13'b0, 3'd7, 1'b0, 3'd7, 12'b0});
      start_req(1'b0, 16'h0777, '0);
      check("R9 busy ready", ready, 0);
      begin
         int wf;
         wf = we_falls;
         @(negedge clk);
         req_valid = 1'b1; req_write = 1'b1; req_addr = 16'hBEEF; req_wdata = 32'hDEAD_DEAD;
         repeat (2) @(negedge clk);
         check("R9 still busy", ready, 0);
         req_valid = 1'b0;
         wait_done("R9 read done");
         check("R9 read data kept", rdata, {16'h0777, ~16'h0777});
         repeat (3) @(negedge clk);
         check("R9 no write strobe", we_falls, wf);
         check("R9 idle after", ready, 1);
         check("R9 address kept", mem_addr, 16'h0777);
      end

      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule